// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a requester and a backing memory. It turns every bit of a backing window into a 32-bit word of its own inside a larger alias region. A read of an alias word fetches the backing bytes that contain the bit and returns that one bit. A write of an alias word reads the backing bytes, sets or clears the one bit, and writes the same bytes back, so software can change a single flag with one store.

The requester side is a valid/ready request channel with a one-cycle response pulse. The backing side is a valid/ready request channel whose response arrives later, in a cycle where `m_resp_valid` is high. Both sides carry a size code and an error flag. The bridge takes one request at a time and keeps `s_req_ready` low until that request has been answered. Backing data is right-justified and little-endian: the byte at the lowest address sits in bits 7:0.

Top module: `bitband_bridge`

## Requirements
- R1: The backing address is `BASE_ADDR | (alias_offset >> 5)`, where alias_offset is the low `ALIAS_W` (25) bits of `s_req_addr`. This address is rounded down to a multiple of the access size before it is issued.
- R2: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. The selected bit index is `alias_offset[6:2]` masked with (8 × bytes − 1). Index bits [4:3] pick the byte lane and bits [2:0] pick the bit within that byte.
- R3: A read returns the selected backing bit in `s_resp_rdata[0]` with bits 31:1 zero. It issues no backing write.
- R4: A write issues a backing read and then a backing write to the same address with the same size. The selected bit becomes `s_req_wdata[0]` and every other backing bit keeps its value.
- R5: A request with size code 3 gets an error response and makes no backing access.
- R6: An error on the backing read is reported to the requester in the next cycle, and no write-back is issued.
- R7: The error status of the backing write-back is passed on as the error of the alias write response.
- R8: `s_req_ready` is high only while the bridge is idle. It stays low from acceptance through the one-cycle `s_resp_valid` pulse.
- R9: After reset, `s_req_ready` is high and both `m_req_valid` and `s_resp_valid` are low.
- R10: Address bits at and above `ALIAS_W` have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req_valid | input | 1 | Alias request valid |
| s_req_ready | output | 1 | Bridge idle and able to accept |
| s_req_write | input | 1 | 1 = alias write, 0 = alias read |
| s_req_addr | input | 32 | Alias address (low 25 bits decoded) |
| s_req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| s_req_wdata | input | 32 | Write data; only bit 0 is used |
| s_resp_valid | output | 1 | One-cycle response pulse |
| s_resp_rdata | output | 32 | Read result: the selected bit in bit 0 |
| s_resp_err | output | 1 | Response error |
| m_req_valid | output | 1 | Backing request valid |
| m_req_ready | input | 1 | Backing request accepted |
| m_req_write | output | 1 | Backing write |
| m_req_addr | output | 32 | Aligned backing byte address |
| m_req_size | output | 2 | Backing size code |
| m_req_wdata | output | 32 | Write-back data, right-justified |
| m_resp_valid | input | 1 | Backing response valid |
| m_resp_rdata | input | 32 | Backing read data, right-justified |
| m_resp_err | input | 1 | Backing response error |

## Verification
Some properties are checked by assertions on every cycle:
- backing-address alignment;
- matching size and address between a write-back and the read that preceded it;
- the absence of write-backs for alias reads;
- the zero upper result bits;
- the one-cycle timing of error replies;
- ready being low whenever the bridge is busy.

Other properties can only be shown by the bench's scenarios, because they need a model of memory contents:
- that the correct bit is chosen at each size;
- that a write leaves every neighbouring bit untouched;
- that upper alias address bits are ignored.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_ADDR_W = 32;
    localparam int BB_DATA_W = 32;
    localparam int BB_IDX_W  = $clog2(BB_DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } bb_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } bb_state_e;

    typedef struct packed {
        logic                 wr;
        bb_size_e             size;
        logic [BB_ADDR_W-1:0] baddr;
        logic [BB_IDX_W-1:0]  bidx;
        logic                 setv;
    } bb_op_t;

    // mask limiting the bit index to the bits fetched
    function automatic logic [BB_IDX_W-1:0] idx_mask(input bb_size_e sz);
        case (sz)
            SZ_BYTE: idx_mask = BB_IDX_W'(7);
            SZ_HALF: idx_mask = BB_IDX_W'(15);
            default: idx_mask = BB_IDX_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bb_pkg::*;
#(
    parameter int                     ALIAS_W   = 25,
    parameter logic [BB_ADDR_W-1:0]   BASE_ADDR = 32'h2000_0000
) (
    input  logic [BB_ADDR_W-1:0] alias_addr,
    input  bb_size_e             size,
    output logic [BB_ADDR_W-1:0] back_addr,
    output logic [BB_IDX_W-1:0]  bit_idx
);
    // one backing byte covers 8 alias words of 4 bytes
    localparam int SHIFT = 5;

    logic [ALIAS_W-1:0]   off;
    logic [BB_ADDR_W-1:0] raw;

    assign off = alias_addr[ALIAS_W-1:0];
    assign raw = BASE_ADDR | BB_ADDR_W'(off >> SHIFT);

    always_comb begin
        case (size)
            SZ_HALF: back_addr = {raw[BB_ADDR_W-1:1], 1'b0};
            SZ_WORD: back_addr = {raw[BB_ADDR_W-1:2], 2'b00};
            default: back_addr = raw;
        endcase
        bit_idx = off[BB_IDX_W+1:2] & idx_mask(size);
    end

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
    import bb_pkg::*;
(
    input  logic [BB_DATA_W-1:0] data_in,
    input  logic [BB_IDX_W-1:0]  bit_idx,
    input  logic                 set_val,
    output logic                 bit_out,
    output logic [BB_DATA_W-1:0] data_mod
);
    localparam int LANES = BB_DATA_W / 8;
    localparam int LSEL_W = $clog2(LANES);

    logic [LANES-1:0]  lane_bit;
    logic [LSEL_W-1:0] lane_sel;
    logic [2:0]        bit_sel;

    assign lane_sel = bit_idx[BB_IDX_W-1:3];
    assign bit_sel  = bit_idx[2:0];

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] byte_in;
        logic [7:0] byte_out;
        assign byte_in = data_in[8*b +: 8];
        always_comb begin
            byte_out = byte_in;
            if (lane_sel == LSEL_W'(b)) begin
                byte_out[bit_sel] = set_val;
            end
        end
        assign lane_bit[b]        = byte_in[bit_sel];
        assign data_mod[8*b +: 8] = byte_out;
    end

    assign bit_out = lane_bit[lane_sel];

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int                   ALIAS_W   = 25,
    parameter logic [BB_ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_req_valid,
    output logic                 s_req_ready,
    input  logic                 s_req_write,
    input  logic [BB_ADDR_W-1:0] s_req_addr,
    input  logic [1:0]           s_req_size,
    input  logic [BB_DATA_W-1:0] s_req_wdata,
    output logic                 s_resp_valid,
    output logic [BB_DATA_W-1:0] s_resp_rdata,
    output logic                 s_resp_err,
    output logic                 m_req_valid,
    input  logic                 m_req_ready,
    output logic                 m_req_write,
    output logic [BB_ADDR_W-1:0] m_req_addr,
    output logic [1:0]           m_req_size,
    output logic [BB_DATA_W-1:0] m_req_wdata,
    input  logic                 m_resp_valid,
    input  logic [BB_DATA_W-1:0] m_resp_rdata,
    input  logic                 m_resp_err
);
    bb_state_e            state;
    bb_op_t               op;
    logic [BB_DATA_W-1:0] wb_data;
    logic                 res_bit;
    logic                 res_err;

    bb_size_e             in_size;
    logic [BB_ADDR_W-1:0] map_addr;
    logic [BB_IDX_W-1:0]  map_idx;
    logic                 lane_bit;
    logic [BB_DATA_W-1:0] lane_data;

    assign in_size = bb_size_e'(s_req_size);

    bb_addr_map #(
        .ALIAS_W   (ALIAS_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_map (
        .alias_addr (s_req_addr),
        .size       (in_size),
        .back_addr  (map_addr),
        .bit_idx    (map_idx)
    );

    bb_bit_lane u_lane (
        .data_in  (m_resp_rdata),
        .bit_idx  (op.bidx),
        .set_val  (op.setv),
        .bit_out  (lane_bit),
        .data_mod (lane_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op      <= '0;
            wb_data <= '0;
            res_bit <= 1'b0;
            res_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (s_req_valid) begin
                        op.wr    <= s_req_write;
                        op.size  <= in_size;
                        op.baddr <= map_addr;
                        op.bidx  <= map_idx;
                        op.setv  <= s_req_wdata[0];
                        res_bit  <= 1'b0;
                        if (in_size == SZ_BAD) begin
                            res_err <= 1'b1;
                            state   <= ST_RESP;
                        end else begin
                            res_err <= 1'b0;
                            state   <= ST_RD_REQ;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (m_req_ready) state <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (m_resp_valid) begin
                        if (m_resp_err) begin
                            res_err <= 1'b1;
                            state   <= ST_RESP;
                        end else if (op.wr) begin
                            wb_data <= lane_data;
                            state   <= ST_WR_REQ;
                        end else begin
                            res_bit <= lane_bit;
                            state   <= ST_RESP;
                        end
                    end
                end
                ST_WR_REQ: begin
                    if (m_req_ready) state <= ST_WR_WAIT;
                end
                ST_WR_WAIT: begin
                    if (m_resp_valid) begin
                        res_err <= m_resp_err;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign s_req_ready  = (state == ST_IDLE);
    assign s_resp_valid = (state == ST_RESP);
    assign s_resp_rdata = {{(BB_DATA_W-1){1'b0}}, res_bit};
    assign s_resp_err   = res_err;

    assign m_req_valid  = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    assign m_req_write  = (state == ST_WR_REQ);
    assign m_req_addr   = op.baddr;
    assign m_req_size   = op.size;
    assign m_req_wdata  = wb_data;

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_req_valid,
    input logic        s_req_ready,
    input logic        s_req_write,
    input logic [1:0]  s_req_size,
    input logic        s_resp_valid,
    input logic [31:0] s_resp_rdata,
    input logic        s_resp_err,
    input logic        m_req_valid,
    input logic        m_req_ready,
    input logic        m_req_write,
    input logic [31:0] m_req_addr,
    input logic [1:0]  m_req_size,
    input logic        m_resp_valid,
    input logic        m_resp_err
);
    logic        op_wr;
    logic [1:0]  op_size;
    logic        last_wr;
    logic [31:0] rd_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_wr     <= 1'b0;
            op_size   <= 2'd0;
            last_wr   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            if (s_req_valid && s_req_ready) begin
                op_wr   <= s_req_write;
                op_size <= s_req_size;
            end
            if (m_req_valid && m_req_ready) begin
                last_wr <= m_req_write;
                if (!m_req_write) rd_addr_q <= m_req_addr;
            end
        end
    end

    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        m_req_valid |-> !((m_req_size == 2'd1 && m_req_addr[0]) ||
                          (m_req_size == 2'd2 && m_req_addr[1:0] != 2'b00)));

    assert_read_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (s_resp_valid && !op_wr) |-> (s_resp_rdata[31:1] == 31'd0));

    assert_no_wb_on_read_R3: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid && m_req_write) |-> op_wr);

    assert_size_kept_R4: assert property (@(posedge clk) disable iff (rst)
        m_req_valid |-> (m_req_size == op_size));

    assert_wb_same_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid && m_req_write) |-> (m_req_addr == rd_addr_q));

    assert_bad_size_R5: assert property (@(posedge clk) disable iff (rst)
        (s_req_valid && s_req_ready && s_req_size == 2'd3)
            |=> (s_resp_valid && s_resp_err && !m_req_valid));

    assert_rd_err_R6: assert property (@(posedge clk) disable iff (rst)
        (m_resp_valid && m_resp_err && !last_wr)
            |=> (s_resp_valid && s_resp_err && !m_req_valid));

    assert_wb_err_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (m_resp_valid && last_wr)
            |=> (s_resp_valid && (s_resp_err == $past(m_resp_err))));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid || s_resp_valid) |-> !s_req_ready);

    assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        s_resp_valid |=> !s_resp_valid);

endmodule

bind bitband_bridge bb_bridge_chk u_chk (.*);

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;

    localparam logic [31:0] BASE = 32'h2000_0000;
    localparam int NVEC = 12;
    localparam int MEMSZ = 64;

    // vector: {write, size[1:0], offset[15:0], wbit}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 16'h0000, 1'b0},
        {1'b0, 2'd0, 16'h0034, 1'b0},
        {1'b0, 2'd1, 16'h0064, 1'b0},
        {1'b0, 2'd2, 16'h00FC, 1'b0},
        {1'b1, 2'd0, 16'h0108, 1'b1},
        {1'b0, 2'd0, 16'h0108, 1'b0},
        {1'b1, 2'd2, 16'h0224, 1'b0},
        {1'b0, 2'd2, 16'h0224, 1'b0},
        {1'b1, 2'd1, 16'h07FC, 1'b1},
        {1'b0, 2'd1, 16'h07FC, 1'b0},
        {1'b1, 2'd0, 16'h03E0, 1'b0},
        {1'b0, 2'd2, 16'h0400, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_req_valid = 1'b0;
    logic        s_req_ready;
    logic        s_req_write = 1'b0;
    logic [31:0] s_req_addr = '0;
    logic [1:0]  s_req_size = '0;
    logic [31:0] s_req_wdata = '0;
    logic        s_resp_valid;
    logic [31:0] s_resp_rdata;
    logic        s_resp_err;
    logic        m_req_valid;
    logic        m_req_ready;
    logic        m_req_write;
    logic [31:0] m_req_addr;
    logic [1:0]  m_req_size;
    logic [31:0] m_req_wdata;
    logic        m_resp_valid = 1'b0;
    logic [31:0] m_resp_rdata = '0;
    logic        m_resp_err = 1'b0;

    always #2 clk = ~clk;

    bitband_bridge u0 (.*);

    // backing memory model
    logic [7:0]  mem    [MEMSZ];
    logic [7:0]  shadow [MEMSZ];
    logic        err_rd = 1'b0;
    logic        err_wr = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [1:0]  last_size = '0;

    assign m_req_ready = 1'b1;

    always @(posedge clk) begin
        m_resp_valid <= 1'b0;
        if (!rst && m_req_valid) begin
            last_addr    <= m_req_addr;
            last_size    <= m_req_size;
            m_resp_valid <= 1'b1;
            if (m_req_write) begin
                wr_cnt     <= wr_cnt + 1;
                m_resp_err <= err_wr;
                if (!err_wr) begin
                    for (int k = 0; k < 4; k++) begin
                        if (k < (1 << m_req_size))
                            mem[6'(m_req_addr[5:0] + 6'(k))] <= m_req_wdata[8*k +: 8];
                    end
                end
            end else begin
                rd_cnt     <= rd_cnt + 1;
                m_resp_err <= err_rd;
                for (int k = 0; k < 4; k++) begin
                    m_resp_rdata[8*k +: 8] <= (k < (1 << m_req_size))
                        ? mem[6'(m_req_addr[5:0] + 6'(k))] : 8'h00;
                end
            end
        end
    end

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_idx(input logic [15:0] off, input logic [1:0] sz);
        logic [5:0] ba;
        ba = off[10:5];
        if (sz == 2'd1) ba[0] = 1'b0;
        if (sz == 2'd2) ba[1:0] = 2'b00;
        return ba;
    endfunction

    function automatic logic [4:0] exp_bit(input logic [15:0] off, input logic [1:0] sz);
        return off[6:2] & 5'((8 << sz) - 1);
    endfunction

    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                          input logic wb, output logic [31:0] rd, output logic er,
                          output logic busy_bad);
        busy_bad = 1'b0;
        @(negedge clk);
        s_req_valid = 1'b1;
        s_req_write = wr;
        s_req_size  = sz;
        s_req_addr  = addr;
        s_req_wdata = {31'h7FFF_FFFE, wb};
        @(negedge clk);
        s_req_valid = 1'b0;
        for (int t = 0; t < 50 && !s_resp_valid; t++) begin
            if (s_req_ready) busy_bad = 1'b1;
            @(negedge clk);
        end
        if (s_req_ready) busy_bad = 1'b1;
        rd = s_resp_rdata;
        er = s_resp_err;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        logic        bb;
        int          rc0;
        int          wc0;
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i]    = 8'(i * 37 + 5);
            shadow[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 ready", 32'(s_req_ready), 32'd1);
        check("R9 m_req_valid", 32'(m_req_valid), 32'd0);
        check("R9 s_resp_valid", 32'(s_resp_valid), 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            logic        vw;
            logic [1:0]  vs;
            logic [15:0] vo;
            logic        vb;
            logic [5:0]  ei;
            logic [4:0]  eb;
            logic [5:0]  byi;
            logic [31:0] aa;
            logic        mism;
            {vw, vs, vo, vb} = VEC[v];
            ei  = exp_idx(vo, vs);
            eb  = exp_bit(vo, vs);
            byi = 6'(ei + 6'(eb[4:3]));
            // R10: upper alias bits vary and must not matter
            aa  = ((v % 2) == 0 ? 32'h2200_0000 : 32'hFE00_0000) | {16'h0, vo};
            rc0 = rd_cnt;
            wc0 = wr_cnt;
            access(vw, vs, aa, vb, rd, er, bb);
            check("R8 ready low while busy", 32'(bb), 32'd0);
            // R1: aligned backing address and size seen by memory
            check("R1 backing addr", last_addr, BASE | 32'(ei));
            check("R4 backing size", 32'(last_size), 32'(vs));
            check("R10 no error", 32'(er), 32'd0);
            if (!vw) begin
                // R2 R3: selected bit in bit 0, upper bits zero, no write
                check("R2 R3 read bit", rd, 32'(shadow[byi][eb[2:0]]));
                check("R3 no write-back", 32'(wr_cnt - wc0), 32'd0);
            end else begin
                shadow[byi][eb[2:0]] = vb;
                mism = 1'b0;
                for (int i = 0; i < MEMSZ; i++)
                    if (mem[i] !== shadow[i]) mism = 1'b1;
                check("R4 memory after write", 32'(mism), 32'd0);
                check("R4 one read one write", 32'((rd_cnt - rc0) * 16 + (wr_cnt - wc0)), 32'h11);
            end
        end

        // R5: bad size code
        rc0 = rd_cnt;
        wc0 = wr_cnt;
        access(1'b0, 2'd3, 32'h2200_0040, 1'b0, rd, er, bb);
        check("R5 err", 32'(er), 32'd1);
        check("R5 no access", 32'(rd_cnt - rc0 + wr_cnt - wc0), 32'd0);

        // R6: backing read error on alias write
        err_rd = 1'b1;
        wc0 = wr_cnt;
        access(1'b1, 2'd0, 32'h2200_0020, 1'b1, rd, er, bb);
        err_rd = 1'b0;
        check("R6 err", 32'(er), 32'd1);
        check("R6 no write-back", 32'(wr_cnt - wc0), 32'd0);
        check("R6 memory kept", 32'(mem[1]), 32'(shadow[1]));

        // R7: write-back error passed through
        err_wr = 1'b1;
        access(1'b1, 2'd2, 32'h2200_0180, ~shadow[12][0], rd, er, bb);
        err_wr = 1'b0;
        check("R7 err passed", 32'(er), 32'd1);
        access(1'b1, 2'd2, 32'h2200_0180, ~shadow[12][0], rd, er, bb);
        check("R7 ok passed", 32'(er), 32'd0);
        shadow[12][0] = ~shadow[12][0];
        check("R7 write landed", 32'(mem[12]), 32'(shadow[12]));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule